// File: doc/BRIEF.md
# Lagged-Fibonacci Carry/Borrow Word Generator

This block produces a stream of pseudo-random words from a circular history of the last S words. Each new word is formed from two older words: the one S steps back (the far tap) and the one P steps back (the near tap), with S > P > 0 fixed when the block is built. A two-bit mode input picks the combining operation. The four choices are plain addition, plain subtraction, addition with a carry kept from the previous step, and subtraction with a borrow kept from the previous step. All arithmetic wraps modulo 2^W.

Software or a neighbouring block first fills the history through a seed write port, which addresses entries by their age. After that, each accepted step request writes the new word over the oldest entry, moves the window forward by one, and presents the word on a valid/ready output. The output register holds one word. While it is valid and not accepted, it keeps its word and new step requests are dropped, not queued. The output never applies back-pressure beyond that single stage. A word the consumer accepts in a cycle can be replaced in that same cycle, so with ready held high the block delivers one word per clock.

Top module: `lfg_gen`

## Requirements
- R1: After reset, out_valid_o is low, the write pointer sits at history slot 0 and the carry/borrow bit is 0. The first word after seeding therefore uses seed index 0 as its far tap and a carry-in of 0.
- R2: A step request is ignored, and produces no valid word, until every seed index 0..S-1 has been written at least once since reset.
- R3: In mode 2'b00 (plain add) the new word is (far + near) mod 2^W. The carry/borrow bit is not used.
- R4: In mode 2'b01 (plain subtract) the new word is (far - near) mod 2^W. The carry/borrow bit is not used.
- R5: In mode 2'b10 (add with carry) the new word is (far + near + c) mod 2^W. The next c is 1 exactly when far + near + c >= 2^W.
- R6: In mode 2'b11 (subtract with borrow) the new word is (far - near - b) mod 2^W. The next b is 1 exactly when far < near + b.
- R7: A change of mode_i clears the carry/borrow bit. A step taken in the same cycle as the change uses the new mode with a carry-in of 0.
- R8: Each produced word replaces the far-tap entry. The window then advances by one, so the word produced at step n is the near tap of step n+P and the far tap of step n+S.
- R9: A seed write to index i (0 = oldest, S-1 = newest) sets that history entry. An index of S or more is ignored. A seed write takes priority over a step request in the same cycle, and that step is dropped.
- R10: While out_valid_o is high and out_ready_i is low, out_data_o and out_valid_o hold, and step requests are dropped. When a valid word is accepted and no step is taken, out_valid_o falls.
- R11: With out_ready_i high and step_i held, a new valid word appears on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Combining mode: 00 add, 01 subtract, 10 add with carry, 11 subtract with borrow |
| seed_we_i | input | 1 | Seed write strobe |
| seed_idx_i | input | $clog2(S) | Seed index by age, 0 oldest |
| seed_data_i | input | W | Seed word |
| step_i | input | 1 | Request one new word |
| out_ready_i | input | 1 | Consumer accepts the output word |
| out_data_o | output | W | Generated word |
| out_valid_o | output | 1 | out_data_o holds an unaccepted word |

## Verification
The bench targets four traps. A boundary sum that just reaches 2^W or a difference that just goes below zero catches a design that drops the carry or inverts the borrow, which would drift off the reference sequence one word later. A mode switch directly after a carry-producing step exposes a stale carry leaking into the new mode. A step that overlaps a seed write, or arrives with one index still unwritten, exposes premature output. Long random runs with stalls and more than S steps show whether the near and far taps are off by one slot, because every word then feeds back through the history.

// File: rtl/lfg_pkg.sv
package lfg_pkg;
  typedef enum logic [1:0] {
    MODE_ADD = 2'b00,
    MODE_SUB = 2'b01,
    MODE_ADC = 2'b10,
    MODE_SBB = 2'b11
  } lfg_mode_e;

  // Upper mode bit selects the chained (carry/borrow) variants.
  function automatic logic mode_chains(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/lfg_history.sv
module lfg_history #(
  parameter int W = 16,
  parameter int S = 17,
  parameter int P = 5,
  localparam int IW = $clog2(S)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          seed_we_i,
  input  logic [IW-1:0] seed_idx_i,
  input  logic [W-1:0]  seed_data_i,
  input  logic          push_i,
  input  logic [W-1:0]  push_data_i,
  output logic [W-1:0]  far_o,
  output logic [W-1:0]  near_o,
  output logic          full_o,
  output logic [IW-1:0] wp_o
);
  localparam int NEAR_OFS = S - P;

  logic [IW-1:0] wp_q;
  logic [S-1:0]  seen_q;
  logic [W-1:0]  slot_q [S];
  logic          seed_ok;
  logic [IW:0]   seed_sum;
  logic [IW-1:0] seed_slot;
  logic [IW:0]   near_sum;
  logic [IW-1:0] near_slot;

  assign seed_ok   = seed_we_i && (int'(seed_idx_i) < S);
  assign seed_sum  = {1'b0, wp_q} + {1'b0, seed_idx_i};
  assign seed_slot = (int'(seed_sum) >= S) ? IW'(int'(seed_sum) - S) : seed_sum[IW-1:0];
  assign near_sum  = {1'b0, wp_q} + (IW+1)'(NEAR_OFS);
  assign near_slot = (int'(near_sum) >= S) ? IW'(int'(near_sum) - S) : near_sum[IW-1:0];

  // One register per history slot; seed and push never collide (push excludes seed).
  for (genvar g = 0; g < S; g++) begin : g_slot
    logic hit_seed, hit_push;
    assign hit_seed = seed_ok && (seed_slot == IW'(g));
    assign hit_push = push_i && (wp_q == IW'(g));
    always_ff @(posedge clk_i) begin
      if (hit_seed)      slot_q[g] <= seed_data_i;
      else if (hit_push) slot_q[g] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      seen_q <= '0;
    end else begin
      if (seed_ok) seen_q[seed_idx_i] <= 1'b1;
      if (push_i)  wp_q <= (int'(wp_q) == S-1) ? '0 : wp_q + 1'b1;
    end
  end

  assign far_o  = slot_q[wp_q];
  assign near_o = slot_q[near_slot];
  assign full_o = &seen_q;
  assign wp_o   = wp_q;
endmodule

// File: rtl/lfg_alu.sv
module lfg_alu #(
  parameter int W = 16
) (
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] far_i,
  input  logic [W-1:0] near_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  import lfg_pkg::*;
  logic [W:0] ext;
  logic [W:0] cin_ext;

  assign cin_ext = {{W{1'b0}}, cin_i};

  always_comb begin
    unique case (lfg_mode_e'(mode_i))
      MODE_ADD: ext = {1'b0, far_i} + {1'b0, near_i};
      MODE_SUB: ext = {1'b0, far_i} - {1'b0, near_i};
      MODE_ADC: ext = {1'b0, far_i} + {1'b0, near_i} + cin_ext;
      default:  ext = {1'b0, far_i} - {1'b0, near_i} - cin_ext;
    endcase
  end

  assign res_o  = ext[W-1:0];
  assign cout_o = ext[W];
endmodule

// File: rtl/lfg_carry.sv
module lfg_carry (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       fire_i,
  input  logic       cout_i,
  output logic       cin_o,
  output logic       cy_o
);
  import lfg_pkg::*;
  logic [1:0] mode_q;
  logic       cy_q;
  logic       switched;

  assign switched = (mode_i != mode_q);
  assign cin_o    = mode_chains(mode_i) && !switched && cy_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mode_q <= MODE_ADD;
      cy_q   <= 1'b0;
    end else begin
      mode_q <= mode_i;
      if (fire_i && mode_chains(mode_i)) cy_q <= cout_i;
      else if (switched)                 cy_q <= 1'b0;
    end
  end

  assign cy_o = cy_q;
endmodule

// File: rtl/lfg_gen.sv
module lfg_gen #(
  parameter int W = 16,
  parameter int S = 17,
  parameter int P = 5,
  localparam int IW = $clog2(S)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          seed_we_i,
  input  logic [IW-1:0] seed_idx_i,
  input  logic [W-1:0]  seed_data_i,
  input  logic          step_i,
  input  logic          out_ready_i,
  output logic [W-1:0]  out_data_o,
  output logic          out_valid_o
);
  logic [W-1:0]  far, near, res;
  logic          full, cin, cout, cy_q, fire;
  logic [IW-1:0] wp;

  assign fire = step_i && !seed_we_i && full && (!out_valid_o || out_ready_i);

  lfg_history #(.W(W), .S(S), .P(P)) u_hist (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .seed_we_i(seed_we_i), .seed_idx_i(seed_idx_i), .seed_data_i(seed_data_i),
    .push_i(fire), .push_data_i(res),
    .far_o(far), .near_o(near), .full_o(full), .wp_o(wp)
  );

  lfg_carry u_cy (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .fire_i(fire), .cout_i(cout), .cin_o(cin), .cy_o(cy_q)
  );

  lfg_alu #(.W(W)) u_alu (
    .mode_i(mode_i), .far_i(far), .near_i(near), .cin_i(cin),
    .res_o(res), .cout_o(cout)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (fire) begin
      out_valid_o <= 1'b1;
      out_data_o  <= res;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lfg_gen_chk.sv
module lfg_gen_chk #(
  parameter int W = 16,
  parameter int S = 17,
  localparam int IW = $clog2(S)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    mode_i,
  input logic          seed_we_i,
  input logic          step_i,
  input logic          out_ready_i,
  input logic [W-1:0]  out_data_o,
  input logic          out_valid_o,
  input logic          fire,
  input logic          cy_q,
  input logic [IW-1:0] wp
);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  assert_seed_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_we_i && (!out_valid_o || out_ready_i) |=> !out_valid_o);

  assert_valid_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(step_i) && !$past(seed_we_i));

  assert_rate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> out_valid_o);

  assert_mode_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != $past(mode_i)) && !fire |=> cy_q == 1'b0);

  assert_ptr_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(wp) < S);

  assert_ptr_move_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> wp != $past(wp));
endmodule

bind lfg_gen lfg_gen_chk #(.W(W), .S(S)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .seed_we_i(seed_we_i),
  .step_i(step_i), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
  .out_valid_o(out_valid_o), .fire(fire), .cy_q(cy_q), .wp(wp)
);

// File: tb/lfg_gen_tb.sv
module lfg_gen_tb;
  localparam int W  = 16;
  localparam int S  = 17;
  localparam int P  = 5;
  localparam int IW = $clog2(S);
  localparam logic [1:0] ADD = 2'b00, SUB = 2'b01, ADC = 2'b10, SBB = 2'b11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = ADD;
  logic          seed_we = 1'b0;
  logic [IW-1:0] seed_idx = '0;
  logic [W-1:0]  seed_data = '0;
  logic          step = 1'b0;
  logic          ready = 1'b1;
  logic [W-1:0]  out_data;
  logic          out_valid;

  always #4 clk = ~clk;

  lfg_gen #(.W(W), .S(S), .P(P)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .seed_we_i(seed_we),
    .seed_idx_i(seed_idx), .seed_data_i(seed_data), .step_i(step),
    .out_ready_i(ready), .out_data_o(out_data), .out_valid_o(out_valid)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model: hist[0] is the oldest word, hist[S-1] the newest.
  logic [W-1:0] hist [S];
  bit   [S-1:0] seen = '0;
  logic         ev = 1'b0;
  logic [W-1:0] ed = '0;
  logic         mc = 1'b0;
  logic [1:0]   mp = ADD;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic st, input logic [1:0] md, input logic rdy,
                     input logic swe, input int sidx, input logic [W-1:0] sdat,
                     input string tag);
    logic   stall, fire, cin, cout;
    longint a, b, r;
    @(negedge clk);
    step = st; mode = md; ready = rdy; seed_we = swe;
    seed_idx = IW'(sidx); seed_data = sdat;
    stall = ev && !rdy;
    fire  = st && !swe && (&seen) && !stall;
    cin   = (md == mp) ? mc : 1'b0;
    if (md != mp) mc = 1'b0;
    mp = md;
    if (swe && sidx < S) begin
      hist[sidx] = sdat;
      seen[sidx] = 1'b1;
    end
    if (fire) begin
      a = longint'(hist[0]);
      b = longint'(hist[S-P]);
      case (md)
        ADD: r = a + b;
        SUB: r = a - b;
        ADC: r = a + b + longint'(cin);
        default: r = a - b - longint'(cin);
      endcase
      cout = (md[0]) ? (r < 0) : (r >= (64'sd1 << W));
      r = r & ((64'sd1 << W) - 1);
      for (int i = 0; i < S-1; i++) hist[i] = hist[i+1];
      hist[S-1] = W'(r);
      ed = W'(r);
      ev = 1'b1;
      if (md[1]) mc = cout;
    end else if (!stall) begin
      ev = 1'b0;
    end
    @(posedge clk); #1;
    chk(tag, "valid", longint'(out_valid), longint'(ev));
    if (ev) chk(tag, "data", longint'(out_data), longint'(ed));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20250611));
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "valid after reset", longint'(out_valid), 0);

    // R2: all but the newest index seeded, steps ignored
    for (int i = 0; i < S-1; i++) cyc(0, ADC, 1, 1, i, W'(16'hF000 + i*16'h0137), "R9");
    cyc(1, ADC, 1, 0, 0, '0, "R2");
    cyc(1, ADC, 1, 0, 0, '0, "R2");
    // R9: index out of range is ignored, so still not seeded
    cyc(0, ADC, 1, 1, S, 16'h1234, "R9");
    cyc(1, ADC, 1, 0, 0, '0, "R9");
    cyc(0, ADC, 1, 1, S-1, 16'hFFFF, "R9");
    // R1: first word uses index 0 as far tap, carry-in 0
    cyc(1, ADC, 1, 0, 0, '0, "R1");
    cyc(1, ADC, 1, 0, 0, '0, "R5");
    cyc(1, ADC, 1, 0, 0, '0, "R5");
    cyc(1, ADC, 1, 0, 0, '0, "R5");
    // R7: switch right after carry-producing steps
    cyc(1, SBB, 1, 0, 0, '0, "R7");
    cyc(1, SBB, 1, 0, 0, '0, "R6");
    // R6 boundary: far just below near
    cyc(0, SBB, 1, 1, 0, 16'h0000, "R9");
    cyc(0, SBB, 1, 1, S-P, 16'h0001, "R9");
    cyc(1, SBB, 1, 0, 0, '0, "R6");
    cyc(1, SBB, 1, 0, 0, '0, "R6");
    // R5 boundary: sum exactly 2^W
    cyc(0, ADC, 1, 1, 0, 16'h8000, "R9");
    cyc(0, ADC, 1, 1, S-P, 16'h8000, "R9");
    cyc(1, ADC, 1, 0, 0, '0, "R5");
    cyc(1, ADC, 1, 0, 0, '0, "R5");
    for (int i = 0; i < 3; i++) cyc(1, ADD, 1, 0, 0, '0, "R3");
    for (int i = 0; i < 3; i++) cyc(1, SUB, 1, 0, 0, '0, "R4");
    // R9: seed in the same cycle as a step drops the step
    cyc(1, SUB, 1, 1, 3, 16'hBEEF, "R9");
    cyc(1, SUB, 1, 0, 0, '0, "R9");
    // R10: back-pressure
    cyc(1, ADD, 0, 0, 0, '0, "R10");
    for (int i = 0; i < 3; i++) cyc(1, ADD, 0, 0, 0, '0, "R10");
    cyc(0, ADD, 1, 0, 0, '0, "R10");
    cyc(0, ADD, 1, 0, 0, '0, "R10");
    // R11: one word per clock
    for (int i = 0; i < 2*S+3; i++) cyc(1, ADC, 1, 0, 0, '0, "R11");
    // R8: long random run
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] md;
      md = ($urandom % 16 == 0) ? 2'($urandom) : mp;
      cyc(($urandom % 4) != 0, md, ($urandom % 4) != 0, ($urandom % 40) == 0,
          int'($urandom % (S+1)), W'($urandom), "R8");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule